// File: doc/BRIEF.md
# PDM Microphone Clock Generator and Bit Capture

This block drives the bit clock for up to four external pulse-density-modulated microphones and collects their one-bit output streams. A master audio clock (24.576 MHz for the 48 kHz family or 22.5792 MHz for the 44.1 kHz family) is divided by a ratio picked by a 2-bit rate code. The result is a 50% duty microphone clock on an output pin. With the 48 kHz master the four codes give 6.144, 3.072, 1.536 and 0.768 MHz. With the 44.1 kHz master they give 5.6448, 2.8224, 1.4112 and 0.7056 MHz.

Two data lines come in, and each is shared by two microphones that drive on opposite clock phases. Every channel has its own edge-select bit, which chooses the phase it latches. The channel samples its line in the last master cycle before the opposite microphone-clock edge, which is the middle of its stable window. Each captured bit comes out with a one-cycle valid strobe in the master clock domain. A per-channel enable gates the strobe. When the rate code changes, the clock is parked low, the divider restarts, and no channel reports data until one full period at the new rate has passed.

Top module: `pdm_mic_front`

## Requirements
- R1: The microphone clock period is 4 << rate_sel master cycles (codes 0..3 give 4, 8, 16, 32). Counting master cycles from the start of a period, the clock is low for the first half and high for the second half.
- R2: After a reset edge, or after any edge at which rate_sel differs from the code in use, the clock is low and a fresh period at the new ratio starts from that edge.
- R3: Channels 0 and 1 take their bits from pdm_din[0]. Channels 2 and 3 take theirs from pdm_din[1].
- R4: With edge_sel[ch] = 0 (rising-edge channel), the line is sampled in the last master cycle of the clock's high phase. ch_valid[ch] and the new ch_bit[ch] appear in the following cycle, which is the first low cycle of the next period.
- R5: With edge_sel[ch] = 1 (falling-edge channel), the line is sampled in the last master cycle of the low phase. The strobe and bit appear in the following cycle, which is the first high cycle.
- R6: No ch_valid is raised for samples taken in the first full period after a reset or rate change.
- R7: ch_valid[ch] is high for exactly one cycle per captured bit. ch_bit[ch] holds its last captured value between strobes.
- R8: While ch_en[ch] = 0, ch_valid[ch] stays 0 and ch_bit[ch] is driven to 0.
- R9: Each channel's edge selection applies to that channel alone. Two channels on the same line may pick the same edge or opposite edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master audio clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 2 | Divide-ratio code (ratio 4 << code) |
| ch_en | input | 4 | Per-channel enable |
| edge_sel | input | 4 | Per-channel latch edge: 0 rising, 1 falling |
| pdm_din | input | 2 | Shared microphone data lines |
| pdm_clk_o | output | 1 | Generated microphone clock |
| ch_bit | output | 4 | Captured bit per channel |
| ch_valid | output | 4 | One-cycle strobe per captured bit |

## Verification
The assertions assume that rate_sel, ch_en, edge_sel and pdm_din are synchronous to the master clock and settle between its rising edges. They also assume that reset is held for at least one edge before checking starts. The stimulus changes every input only just after a falling master-clock edge. It sweeps all four rate codes in rising and falling order, all sixteen edge-select patterns and several enable masks. It also changes the rate at irregular points inside a period, so the restart and settling window are crossed from every phase.

// File: rtl/pdm_cap_pkg.sv
package pdm_cap_pkg;
    localparam int NUM_CH        = 4;
    localparam int NUM_LINES     = 2;
    localparam int RATE_W        = 2;
    localparam int BASE_DIV_LOG2 = 2;
    localparam int CH_PER_LINE   = NUM_CH / NUM_LINES;
    localparam int LINE_W        = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
    localparam int CNT_W         = BASE_DIV_LOG2 + (1 << RATE_W) - 1;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_kind_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } smp_ev_t;

    function automatic logic [CNT_W-1:0] div_last(input logic [RATE_W-1:0] code);
        int unsigned span;
        span = 32'd1 << (BASE_DIV_LOG2 + int'(code));
        return CNT_W'(span - 1);
    endfunction

    function automatic logic [CNT_W-1:0] half_last(input logic [RATE_W-1:0] code);
        int unsigned span;
        span = 32'd1 << (BASE_DIV_LOG2 + int'(code) - 1);
        return CNT_W'(span - 1);
    endfunction

    function automatic int line_of(input int ch);
        return ch / CH_PER_LINE;
    endfunction
endpackage

// File: rtl/pdm_clk_div.sv
module pdm_clk_div
    import pdm_cap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [RATE_W-1:0] rate_i,
    output logic              pdm_clk_o,
    output smp_ev_t           ev_o
);
    logic [RATE_W-1:0] rate_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              clk_q;
    logic              settle_q;
    logic [CNT_W-1:0]  last_c;
    logic [CNT_W-1:0]  half_c;
    logic              changed;

    always_comb begin
        last_c  = div_last(rate_q);
        half_c  = half_last(rate_q);
        changed = (rate_i != rate_q);
    end

    always_ff @(posedge clk) begin
        if (rst || changed) begin
            rate_q   <= rate_i;
            cnt_q    <= '0;
            clk_q    <= 1'b0;
            settle_q <= 1'b1;
        end else if (cnt_q == last_c) begin
            cnt_q    <= '0;
            clk_q    <= 1'b0;
            settle_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == half_c) clk_q <= 1'b1;
        end
    end

    always_comb begin
        ev_o.rise = !settle_q && !changed && (cnt_q == last_c);
        ev_o.fall = !settle_q && !changed && (cnt_q == half_c);
    end

    assign pdm_clk_o = clk_q;

    assert_restart_on_rate_R2: assert property (@(posedge clk) disable iff (rst)
        (rate_i != rate_q) |=> (!pdm_clk_o && cnt_q == '0));

    assert_rise_slot_before_fall_R4: assert property (@(posedge clk) disable iff (rst)
        ev_o.rise |=> $fell(pdm_clk_o));

    assert_fall_slot_before_rise_R5: assert property (@(posedge clk) disable iff (rst)
        ev_o.fall |=> $rose(pdm_clk_o));
endmodule

// File: rtl/pdm_ch_capture.sv
module pdm_ch_capture
    import pdm_cap_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    en_i,
    input  logic    edge_i,
    input  logic    din_i,
    input  smp_ev_t ev_i,
    output logic    bit_o,
    output logic    valid_o
);
    logic hit;
    logic bit_q;
    logic valid_q;

    always_comb begin
        hit = (edge_kind_e'(edge_i) == EDGE_RISE) ? ev_i.rise : ev_i.fall;
    end

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            bit_q   <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= hit;
            if (hit) bit_q <= din_i;
        end
    end

    assign bit_o   = bit_q;
    assign valid_o = valid_q;

    assert_valid_needs_enable_R8: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> $past(en_i));

    assert_disabled_bit_zero_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(en_i) |-> !bit_o);
endmodule

// File: rtl/pdm_mic_front.sv
module pdm_mic_front
    import pdm_cap_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [RATE_W-1:0]    rate_sel,
    input  logic [NUM_CH-1:0]    ch_en,
    input  logic [NUM_CH-1:0]    edge_sel,
    input  logic [NUM_LINES-1:0] pdm_din,
    output logic                 pdm_clk_o,
    output logic [NUM_CH-1:0]    ch_bit,
    output logic [NUM_CH-1:0]    ch_valid
);
    smp_ev_t ev;

    pdm_clk_div u_div (
        .clk      (clk),
        .rst      (rst),
        .rate_i   (rate_sel),
        .pdm_clk_o(pdm_clk_o),
        .ev_o     (ev)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        localparam int LINE = line_of(ch);
        pdm_ch_capture u_cap (
            .clk    (clk),
            .rst    (rst),
            .en_i   (ch_en[ch]),
            .edge_i (edge_sel[ch]),
            .din_i  (pdm_din[LINE]),
            .ev_i   (ev),
            .bit_o  (ch_bit[ch]),
            .valid_o(ch_valid[ch])
        );
    end
endmodule

// File: tb/sim_pdm_mic_front.sv
module sim_pdm_mic_front;
    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] rate_sel;
    logic [3:0] ch_en;
    logic [3:0] edge_sel;
    logic [1:0] pdm_din;
    logic       pdm_clk_o;
    logic [3:0] ch_bit;
    logic [3:0] ch_valid;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int          m = 0;
    logic [1:0]  rate_m = 2'd0;
    logic [1:0]  prev_d = 2'd0;
    logic [3:0]  exp_bit = 4'd0;
    logic [31:0] lfsr = 32'h1234_5678;

    always #5 clk = ~clk;

    pdm_mic_front u0 (
        .clk(clk), .rst(rst), .rate_sel(rate_sel), .ch_en(ch_en),
        .edge_sel(edge_sel), .pdm_din(pdm_din), .pdm_clk_o(pdm_clk_o),
        .ch_bit(ch_bit), .ch_valid(ch_valid)
    );

    // Reference timeline: edges since the last reset or rate change
    always @(posedge clk) begin
        if (rst || rate_sel != rate_m) begin
            m      <= 0;
            rate_m <= rate_sel;
        end else begin
            m <= m + 1;
        end
        prev_d <= pdm_din;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_cycle();
        int dv = 4 << rate_m;
        int hf = dv / 2;
        int ph = m % dv;
        logic exp_clk = (ph >= hf);
        chk(pdm_clk_o == exp_clk, (m < dv) ? "R2 clock after restart" : "R1 clock shape",
            pdm_clk_o, exp_clk);
        for (int ch = 0; ch < 4; ch++) begin
            int   line = ch / 2;
            bit   cond;
            bit   ev;
            logic ev_exp;
            string tag;
            cond = (edge_sel[ch] == 1'b0) ? (ph == 0) : (ph == hf);
            ev   = (edge_sel[ch] == 1'b0) ? (cond && m >= 2*dv) : (cond && m >= dv + hf);
            ev_exp = !rst && ch_en[ch] && ev;
            if (rst || !ch_en[ch]) exp_bit[ch] = 1'b0;
            else if (ev) exp_bit[ch] = prev_d[line];
            if (!ch_en[ch]) tag = "R8 disabled strobe";
            else if (cond && !ev) tag = "R6 settling strobe";
            else if (edge_sel[ch]) tag = "R5,R9 falling strobe";
            else tag = "R4,R9 rising strobe";
            chk(ch_valid[ch] == ev_exp, tag, ch_valid[ch], ev_exp);
            chk(ch_bit[ch] == exp_bit[ch], ch_en[ch] ? "R3,R7 captured bit" : "R8 disabled bit",
                ch_bit[ch], exp_bit[ch]);
        end
    endtask

    task automatic step();
        @(negedge clk);
        check_cycle();
        lfsr = lfsr * 32'd1103515245 + 32'd12345;
        pdm_din = lfsr[17:16];
    endtask

    initial begin
        rst = 1'b1; rate_sel = 2'd0; ch_en = 4'hF; edge_sel = 4'h0; pdm_din = 2'b00;
        repeat (3) step();
        rst = 1'b0;
        // Rising order of rate codes, every edge pattern, several enable masks
        for (int r = 0; r < 4; r++) begin
            for (int e = 0; e < 16; e++) begin
                rate_sel = 2'(r);
                edge_sel = 4'(e);
                ch_en    = (e % 4 == 3) ? 4'(e ^ r) : 4'hF;
                repeat ((e == 0 ? 3 : 2) * (4 << r)) step();
            end
        end
        // Falling order of rate codes
        for (int r = 3; r >= 0; r--) begin
            rate_sel = 2'(r);
            edge_sel = 4'(4'b0110 ^ r);
            ch_en    = 4'hF;
            repeat (4 * (4 << r)) step();
        end
        // Rate changes at irregular points inside a period
        for (int k = 0; k < 12; k++) begin
            rate_sel = 2'((k * 3 + 1) % 4);
            edge_sel = 4'((k * 5) % 16);
            ch_en    = (k % 3 == 0) ? 4'b1010 : 4'hF;
            repeat (5 + k * 7) step();
        end
        // Reset in mid-stream
        rst = 1'b1;
        repeat (2) step();
        rst = 1'b0;
        rate_sel = 2'd1; edge_sel = 4'b1001; ch_en = 4'hF;
        repeat (40) step();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule